// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This block gathers the interrupt causes of an SPI controller into one status word, filters them through a software-controlled mask and drives a single interrupt line. Some causes are short event pulses from the datapath: receive overflow, mode fault and transmit underflow. These are captured in sticky bits that software acknowledges by writing ones. The other causes are live levels that always show the present FIFO state: transmit full, receive not empty, receive full, and transmit fill level below a programmable watermark. Writes cannot clear these level bits.

Software sees a small register port. The mask has no directly writable register. It is changed through two write-only strobe registers, one that sets bits and one that clears them, and a read-only register returns its current value. The register port is plain: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` is a combinational function of `reg_addr` with no handshake or back-pressure. The FIFOs and the serial engine sit outside the block and only drive its event and level pins.

Status bit positions, shared by the status, set, clear and mask registers: bit0 receive overflow, bit1 mode fault, bit2 transmit level below watermark, bit3 transmit full, bit4 receive not empty, bit5 receive full, bit6 transmit underflow.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, every sticky status bit reads 0, the watermark reads 1 and `irq` is 0.
- R2: Register offsets on `reg_addr` are fixed: status 0x04, mask-set 0x08 (write-only), mask-clear 0x0C (write-only), mask 0x10 (read-only), watermark 0x14.
- R3: Bits 0, 1 and 6 are sticky. A one-cycle pulse on `ev_rx_ovf`, `ev_mode_fault` or `ev_tx_unf` sets bit0, bit1 or bit6 at that clock edge, and the bit holds until it is cleared.
- R4: Writing the status offset clears each sticky bit whose data bit is 1 and leaves a bit whose data bit is 0 unchanged. If an event pulse and a clearing write hit the same bit at the same edge, the bit ends up set.
- R5: Bits 3, 4 and 5 follow `tx_full`, `rx_not_empty` and `rx_full` in the same cycle, and writing ones to them at the status offset does not change them.
- R6: Bit2 reads 1 exactly when `tx_level` is strictly less than the watermark value.
- R7: A write to offset 0x08 sets the mask bits written as 1, a write to 0x0C clears the mask bits written as 1, and other mask bits keep their value.
- R8: `irq` is a register. At each clock edge it takes the OR over all seven bits of (status AND mask) as it stood before that edge, so it follows a sticky event two edges after the pulse and a level or mask change one edge after it.
- R9: Reads of 0x08, 0x0C and any offset not listed in R2 return 0. A read of 0x10 returns the mask, and a read of 0x04 returns the status.
- R10: A write to 0x14 loads the low watermark-width bits of `reg_wdata` into the watermark, and reads of 0x14 return that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Combinational read data for `reg_addr` |
| ev_rx_ovf | input | 1 | Receive overflow event pulse |
| ev_mode_fault | input | 1 | Mode fault event pulse |
| ev_tx_unf | input | 1 | Transmit underflow event pulse |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_full | input | 1 | Transmit FIFO full level |
| rx_not_empty | input | 1 | Receive FIFO holds data |
| rx_full | input | 1 | Receive FIFO full level |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with FIFO_DEPTH = 8, which gives a 4-bit level and watermark and a 7-bit register word. At that size it can sweep the watermark comparison across the whole range from an empty FIFO to a full one, and it can check that a watermark write truncates wide data. With the register word exactly as wide as the status field, every data bit the bench drives lands on a defined status or mask bit. This lets the vector table check set, clear and acknowledge combinations bit by bit.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NB = 7;

  // bit positions shared by status, set, clear and mask registers
  localparam int B_RX_OVF   = 0;
  localparam int B_MODE_F   = 1;
  localparam int B_TX_LOW   = 2;
  localparam int B_TX_FULL  = 3;
  localparam int B_RX_NE    = 4;
  localparam int B_RX_FULL  = 5;
  localparam int B_TX_UNF   = 6;

  localparam logic [NB-1:0] STICKY_BITS =
    NB'((1 << B_RX_OVF) | (1 << B_MODE_F) | (1 << B_TX_UNF));

  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_MSET   = 8'h08;
  localparam logic [7:0] OFS_MCLR   = 8'h0C;
  localparam logic [7:0] OFS_MASK   = 8'h10;
  localparam logic [7:0] OFS_WMARK  = 8'h14;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int NB = 7,
  parameter logic [NB-1:0] KEEP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] q_o
);
  logic [NB-1:0] q;

  // set has priority over a simultaneous clear so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr_i) | set_i) & KEEP;
  end

  assign q_o = q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(q & ~clr_i)) == $past(q & ~clr_i)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & KEEP) != '0) |=> ((q & $past(set_i & KEEP)) == $past(set_i & KEEP)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en_i,
  input  logic          clr_en_i,
  input  logic [NB-1:0] bits_i,
  output logic [NB-1:0] mask_o
);
  logic [NB-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= '0;
    else if (set_en_i) mask_q <= mask_q | bits_i;
    else if (clr_en_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !set_en_i) |=> ((mask_q & $past(bits_i)) == '0));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en_i && !clr_en_i) |=> $stable(mask_q));
endmodule

// File: rtl/irq_wmark_cmp.sv
module irq_wmark_cmp #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] wdata_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] wmark_o,
  output logic             below_o
);
  logic [LVL_W-1:0] wm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    wm_q <= LVL_W'(1);
    else if (wr_i) wm_q <= wdata_i;
  end

  assign wmark_o = wm_q;
  assign below_o = (level_i < wm_q);

  p_wm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(wm_q));

  p_wm_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (wm_q == $past(wdata_i)));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int ADDR_W = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int REG_W = (LVL_W > NB) ? LVL_W : NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_rx_ovf,
  input  logic              ev_mode_fault,
  input  logic              ev_tx_unf,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              tx_full,
  input  logic              rx_not_empty,
  input  logic              rx_full,
  output logic              irq
);
  logic [NB-1:0]    wbits;
  logic             hit_st, hit_set, hit_clr, hit_msk, hit_wm;
  logic [NB-1:0]    ev_vec, clr_vec, sticky, live, status, mask;
  logic [LVL_W-1:0] wmark;
  logic             below;
  logic             irq_q;

  assign wbits   = reg_wdata[NB-1:0];
  assign hit_st  = (reg_addr == ADDR_W'(OFS_STATUS));
  assign hit_set = (reg_addr == ADDR_W'(OFS_MSET));
  assign hit_clr = (reg_addr == ADDR_W'(OFS_MCLR));
  assign hit_msk = (reg_addr == ADDR_W'(OFS_MASK));
  assign hit_wm  = (reg_addr == ADDR_W'(OFS_WMARK));

  always_comb begin
    ev_vec = '0;
    ev_vec[B_RX_OVF] = ev_rx_ovf;
    ev_vec[B_MODE_F] = ev_mode_fault;
    ev_vec[B_TX_UNF] = ev_tx_unf;
  end

  assign clr_vec = (reg_wr && hit_st) ? wbits : '0;

  irq_sticky_bank #(.NB(NB), .KEEP(STICKY_BITS)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_vec),
    .clr_i (clr_vec),
    .q_o   (sticky)
  );

  irq_mask_reg #(.NB(NB)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (reg_wr && hit_set),
    .clr_en_i (reg_wr && hit_clr),
    .bits_i   (wbits),
    .mask_o   (mask)
  );

  irq_wmark_cmp #(.LVL_W(LVL_W)) u_wmark (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr && hit_wm),
    .wdata_i (reg_wdata[LVL_W-1:0]),
    .level_i (tx_level),
    .wmark_o (wmark),
    .below_o (below)
  );

  always_comb begin
    live = '0;
    live[B_TX_LOW]  = below;
    live[B_TX_FULL] = tx_full;
    live[B_RX_NE]   = rx_not_empty;
    live[B_RX_FULL] = rx_full;
  end

  // each bit is taken from the sticky bank or the live pins, chosen per position
  for (genvar i = 0; i < NB; i++) begin : g_stat
    if (STICKY_BITS[i]) begin : g_s
      assign status[i] = sticky[i];
    end else begin : g_l
      assign status[i] = live[i] | sticky[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_st)       reg_rdata = REG_W'(status);
    else if (hit_msk) reg_rdata = REG_W'(mask);
    else if (hit_wm)  reg_rdata = REG_W'(wmark);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & mask);
  end

  assign irq = irq_q;

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status & mask) != '0));

  p_live_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_st && tx_full) |=> ($past(tx_full) == status[B_TX_FULL]) || !tx_full);
endmodule

// File: tb/spi_irq_ctrl_tb_top.sv
module spi_irq_ctrl_tb_top;
  localparam int DEPTH = 8;
  localparam int LW = 4;
  localparam int RW = 7;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [6:0] wdata;
    logic [2:0] ev;    // {underflow, mode fault, overflow}
    logic [3:0] lvl;
    logic       txf;
    logic       rxne;
    logic       rxf;
    logic [6:0] est;
    logic [6:0] emask;
    logic       eirq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 7'h00, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b0},
    '{1'b0, 8'h00, 7'h00, 3'b010, 4'd1, 1'b0, 1'b0, 1'b0, 7'h02, 7'h00, 1'b0},
    '{1'b1, 8'h08, 7'h02, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h02, 7'h02, 1'b1},
    '{1'b1, 8'h04, 7'h00, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h02, 7'h02, 1'b1},
    '{1'b1, 8'h04, 7'h02, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h00, 7'h02, 1'b0},
    '{1'b0, 8'h00, 7'h00, 3'b101, 4'd1, 1'b0, 1'b0, 1'b0, 7'h41, 7'h02, 1'b0},
    '{1'b1, 8'h08, 7'h41, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h41, 7'h43, 1'b1},
    '{1'b1, 8'h04, 7'h01, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h40, 7'h43, 1'b1},
    '{1'b1, 8'h0C, 7'h40, 3'b000, 4'd1, 1'b0, 1'b0, 1'b0, 7'h40, 7'h03, 1'b0},
    '{1'b1, 8'h04, 7'h7F, 3'b000, 4'd1, 1'b0, 1'b1, 1'b0, 7'h10, 7'h03, 1'b0},
    '{1'b1, 8'h08, 7'h10, 3'b000, 4'd1, 1'b0, 1'b1, 1'b0, 7'h10, 7'h13, 1'b1},
    '{1'b0, 8'h00, 7'h00, 3'b000, 4'd1, 1'b1, 1'b0, 1'b1, 7'h28, 7'h13, 1'b0},
    '{1'b0, 8'h00, 7'h00, 3'b000, 4'd0, 1'b1, 1'b0, 1'b1, 7'h2C, 7'h13, 1'b0},
    '{1'b1, 8'h08, 7'h24, 3'b000, 4'd0, 1'b1, 1'b0, 1'b1, 7'h2C, 7'h37, 1'b1},
    '{1'b1, 8'h0C, 7'h7F, 3'b000, 4'd0, 1'b1, 1'b0, 1'b1, 7'h2C, 7'h00, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          ev_rx_ovf = 1'b0, ev_mode_fault = 1'b0, ev_tx_unf = 1'b0;
  logic [LW-1:0] tx_level = 4'd1;
  logic          tx_full = 1'b0, rx_not_empty = 1'b0, rx_full = 1'b0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_irq_ctrl #(.FIFO_DEPTH(DEPTH), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rx_ovf(ev_rx_ovf),
    .ev_mode_fault(ev_mode_fault), .ev_tx_unf(ev_tx_unf), .tx_level(tx_level),
    .tx_full(tx_full), .rx_not_empty(rx_not_empty), .rx_full(rx_full), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [6:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h04, v); chk("R1 status", v, 0);
    rd(8'h10, v); chk("R1 mask", v, 0);
    rd(8'h14, v); chk("R1 wmark", v, 1);
    chk("R1 irq", int'(irq), 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      reg_wr = VECS[k].wr; reg_addr = VECS[k].addr; reg_wdata = VECS[k].wdata;
      {ev_tx_unf, ev_mode_fault, ev_rx_ovf} = VECS[k].ev;
      tx_level = VECS[k].lvl; tx_full = VECS[k].txf;
      rx_not_empty = VECS[k].rxne; rx_full = VECS[k].rxf;
      @(negedge clk);
      reg_wr = 1'b0; {ev_tx_unf, ev_mode_fault, ev_rx_ovf} = 3'b000;
      @(negedge clk);
      rd(8'h04, v); chk($sformatf("R3/R4/R5/R6 status vec%0d", k), v, int'(VECS[k].est));
      rd(8'h10, v); chk($sformatf("R7 mask vec%0d", k), v, int'(VECS[k].emask));
      chk($sformatf("R8 irq vec%0d", k), int'(irq), int'(VECS[k].eirq));
    end

    tx_level = 4'd1; tx_full = 1'b0; rx_full = 1'b0; rx_not_empty = 1'b0;

    // R4 set wins over a clearing write at the same edge
    @(negedge clk);
    ev_mode_fault = 1'b1; reg_addr = 8'h04; reg_wdata = 7'h02; reg_wr = 1'b1;
    @(negedge clk);
    ev_mode_fault = 1'b0; reg_wr = 1'b0;
    rd(8'h04, v); chk("R4 set wins", v, 32'h02);
    wr1(8'h04, 7'h02);
    rd(8'h04, v); chk("R4 cleared", v, 0);

    // R5 live bit ignores acknowledge
    tx_full = 1'b1;
    wr1(8'h04, 7'h08);
    rd(8'h04, v); chk("R5 tx_full kept", v, 32'h08);
    tx_full = 1'b0;
    #1; rd(8'h04, v); chk("R5 tx_full follows", v, 0);

    // R8 edge timing
    wr1(8'h08, 7'h02);
    @(negedge clk);
    ev_mode_fault = 1'b1;
    @(negedge clk);
    ev_mode_fault = 1'b0;
    chk("R8 irq one edge after pulse", int'(irq), 0);
    @(negedge clk);
    chk("R8 irq two edges after pulse", int'(irq), 1);
    @(negedge clk);
    reg_addr = 8'h04; reg_wdata = 7'h02; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 irq lags acknowledge", int'(irq), 1);
    @(negedge clk);
    chk("R8 irq drops", int'(irq), 0);

    // R9 write-only and unmapped offsets read zero
    rd(8'h08, v); chk("R9 set reg reads 0", v, 0);
    rd(8'h0C, v); chk("R9 clr reg reads 0", v, 0);
    rd(8'h30, v); chk("R9 unmapped reads 0", v, 0);
    rd(8'h10, v); chk("R9 mask readback", v, 32'h02);

    // R10 / R6 watermark
    wr1(8'h14, 7'h75);
    rd(8'h14, v); chk("R10 wmark truncated", v, 5);
    tx_level = 4'd4;
    #1; rd(8'h04, v); chk("R6 level below", v, 32'h04);
    tx_level = 4'd5;
    #1; rd(8'h04, v); chk("R6 level equal", v, 0);
    wr1(8'h14, 7'h08);
    tx_level = 4'd8;
    #1; rd(8'h04, v); chk("R6 full level equal depth", v, 0);
    tx_level = 4'd0;
    #1; rd(8'h04, v); chk("R6 empty below depth", v, 32'h04);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule